// File: doc/BRIEF.md
# Switchable Domain Sleep and Wake Sequencer

This always-on controller moves one switchable logic domain between running, powered-down and shut-down states. It is clocked from the 32 kHz always-on clock. When the CPU reports deep sleep, it takes the domain down in ordered steps: first reset, then the clock, then power. A wake trigger brings the domain back up through the same steps in reverse order. When the domain goes down, the controller captures its configuration. That configuration selects between a real and a virtual power-off (power stays on but reset and clock gating still apply), between an immediate and a fixed-delay wake-up, between no clock and the low-frequency clock while down, and whether each RAM bank is retained or switched off.

A shut-down request turns everything off, including every RAM bank. It only takes effect once the CPU reports deep sleep. While the debug domain is active, the controller ignores all sleep requests. A small write-one-to-clear register records the warm-reset and reset-source flags.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset, the domain is powered (`dom_pwr_on`=1) with reset released (`dom_rst`=0) and `dom_clk_sel`=2'b11 (high-frequency). Both RAM vectors are 0, `shutdown_o`=0 and `rst_status`=0. Clock select codes are: 2'b00 no clock, 2'b01 low-frequency, 2'b11 high-frequency.
- R2: Suppose `deep_sleep` is sampled high while the domain is active and debug is inactive. One cycle later `dom_rst` rises. The cycle after that, the clock leaves high-frequency. The cycle after that, power is removed if the mode is real. Power is never off unless reset is asserted and the clock is not high-frequency.
- R3: While down, the clock select is 2'b01 if `pd_clk_lf` was high at the request and 2'b00 otherwise. It returns to 2'b11 without any software action during wake-up.
- R4: If `virt_off`=1 or `pd_en`=0 at the request, the reset and clock steps still happen, but `dom_pwr_on` stays 1 and no RAM bank is retained or switched off.
- R5: In a real power-down, bank i is retained (`ram_ret[i]`=1) when `ret_mask[i]` was 1 at the request, and switched off (`ram_off[i]`=1) otherwise. No bank ever has both bits set.
- R6: In immediate mode (`wake_fixed`=0), a wake trigger sampled while down restores power on the next cycle. The high-frequency clock returns one cycle after that, and reset is released one cycle after that.
- R7: In fixed mode (`wake_fixed`=1), the wake-up takes exactly WAKE_DLY cycles longer than in immediate mode (default 16).
- R8: While `dbg_active`=1, `deep_sleep` has no effect: the domain stays active.
- R9: `sd_en` alone does nothing while `deep_sleep` is low. With both high, the domain reaches shut-down: power off, clock 2'b00, every bank off, and `shutdown_o`=1.
- R10: A wake trigger sampled during the reset or clock-gating step aborts the power-down. On the next cycle the domain is fully active.
- R11: `rst_status` bit 0 is the warm-reset flag and bit 1 is the reset-source flag. A 1 on `rst_flag_set` sets the bit. A 1 on `rst_flag_clr` clears it. If both arrive in the same cycle, set wins.
- R12: Configuration inputs that change while the domain is down do not affect the down-state outputs. A wake trigger while the domain is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_en | input | 1 | Power-down enable (0 gives virtual power-down) |
| virt_off | input | 1 | Virtual power-off mode |
| wake_fixed | input | 1 | 1 = fixed-delay wake, 0 = immediate wake |
| pd_clk_lf | input | 1 | Clock while down: 1 = low-frequency, 0 = none |
| ret_mask | input | NUM_BANKS | Per-bank RAM retention enable |
| sd_en | input | 1 | Shut-down enable |
| dbg_active | input | 1 | Debug domain active |
| deep_sleep | input | 1 | CPU deep-sleep indication (sleep request) |
| wake_evt | input | 1 | Wake trigger |
| rst_flag_set | input | 2 | Set pulses for the status flags |
| rst_flag_clr | input | 2 | Write-one-to-clear strobes |
| dom_pwr_on | output | 1 | Domain power switch |
| dom_rst | output | 1 | Domain reset, active high |
| dom_clk_sel | output | 2 | Domain clock select |
| ram_ret | output | NUM_BANKS | Bank in retention |
| ram_off | output | NUM_BANKS | Bank powered off |
| shutdown_o | output | 1 | Device shut-down state |
| rst_status | output | 2 | Reset status flags |

## Verification
The hardest situations to reach are the two abort windows. Each lasts a single cycle, in the reset step and in the clock-gating step, so the wake trigger must land on exactly the cycle after the request or the cycle after that. Directed tests place the trigger at each of those offsets. A second hard case is a configuration change while the domain is down. The bench flips the mask and clock source at that point and checks that the outputs hold. Random loops mix mode, mask, clock source and wake timing, and each run steps through a full down-and-up sequence with every intermediate step compared.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the domain sleep/wake sequencer.
package pwr_seq_pkg;
    typedef enum logic [2:0] {
        ST_ACT, ST_DN_RST, ST_DN_CLK, ST_OFF, ST_WAIT, ST_UP_PWR, ST_UP_CLK
    } seq_state_t;

    typedef enum logic [1:0] {
        CLK_NONE = 2'b00, CLK_LF = 2'b01, CLK_HF = 2'b11
    } clk_sel_t;

    typedef struct packed {
        logic virt;   // keep power on while down
        logic shut;   // full shut-down
        logic lf;     // low-frequency clock while down
        logic fixed;  // fixed-delay wake-up
    } sleep_cfg_t;
endpackage

// File: rtl/pwr_seq_fsm.sv
// Sleep/wake step sequencer. Captures the configuration and retention mask
// when a sleep request is accepted, walks reset -> clock -> power on the way
// down and the reverse on the way up, and counts the fixed wake delay.
// Assumes WAKE_DLY >= 1 and single-cycle wake/sleep pulses are enough.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int WAKE_DLY  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 deep_sleep,
    input  logic                 wake_evt,
    input  logic                 dbg_active,
    input  sleep_cfg_t           cfg_in,
    input  logic [NUM_BANKS-1:0] mask_in,
    output seq_state_t           state,
    output sleep_cfg_t           cfg_q,
    output logic [NUM_BANKS-1:0] mask_q
);
    localparam int CNT_W = $clog2(WAKE_DLY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_DLY - 1);

    logic [CNT_W-1:0] cnt;

    // State walk, configuration capture and wake-delay counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_ACT;
            cfg_q  <= '0;
            mask_q <= '0;
            cnt    <= '0;
        end else begin
            case (state)
                ST_ACT: if (deep_sleep && !dbg_active) begin
                    state  <= ST_DN_RST;
                    cfg_q  <= cfg_in;
                    mask_q <= mask_in;
                end
                ST_DN_RST: state <= wake_evt ? ST_ACT : ST_DN_CLK;
                ST_DN_CLK: state <= wake_evt ? ST_ACT : ST_OFF;
                ST_OFF: if (wake_evt) begin
                    cnt   <= '0;
                    state <= cfg_q.fixed ? ST_WAIT : ST_UP_PWR;
                end
                ST_WAIT: begin
                    if (cnt == LAST) state <= ST_UP_PWR;
                    else             cnt   <= cnt + 1'b1;
                end
                ST_UP_PWR: state <= ST_UP_CLK;
                ST_UP_CLK: state <= ST_ACT;
                default:   state <= ST_ACT;
            endcase
        end
    end

    // R8: debug holds the domain active
    a_r8_dbg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACT && dbg_active) |=> state == ST_ACT);
    // R9: nothing leaves active without the deep-sleep indication
    a_r9_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACT && !deep_sleep) |=> state == ST_ACT);
    // R7: the fixed wait ends only after its full count
    a_r7_wait_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && cnt != LAST) |=> state == ST_WAIT);
    // R10: a wake during the down steps returns to active
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_DN_RST || state == ST_DN_CLK) && wake_evt) |=> state == ST_ACT);
endmodule

// File: rtl/pwr_seq_outmap.sv
// Decodes the sequencer step and captured configuration into the domain
// power switch, reset, clock select and per-bank RAM controls.
// Assumes the state and configuration are registered upstream.
module pwr_seq_outmap
    import pwr_seq_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  seq_state_t           state,
    input  logic                 virt,
    input  logic                 shut,
    input  logic                 lf,
    input  logic [NUM_BANKS-1:0] mask_q,
    output logic                 pwr_on,
    output logic                 rst_o,
    output clk_sel_t             clk_sel,
    output logic [NUM_BANKS-1:0] ret_o,
    output logic [NUM_BANKS-1:0] off_o,
    output logic                 shut_o
);
    logic down, gated, real_off;
    clk_sel_t pd_src;

    // Step decode into domain controls.
    always_comb begin
        down     = (state == ST_OFF) || (state == ST_WAIT);
        gated    = down || (state == ST_DN_CLK) || (state == ST_UP_PWR);
        real_off = down && (shut || !virt);
        pd_src   = shut ? CLK_NONE : (lf ? CLK_LF : CLK_NONE);
        clk_sel  = gated ? pd_src : CLK_HF;
        pwr_on   = !real_off;
        rst_o    = (state != ST_ACT);
        shut_o   = down && shut;
    end

    // One retention/off pair per RAM bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign ret_o[b] = real_off && !shut && mask_q[b];
        assign off_o[b] = real_off && (shut || !mask_q[b]);
    end
endmodule

// File: rtl/pwr_rst_status.sv
// Write-one-to-clear reset status flags; a set in the same cycle wins.
module pwr_rst_status #(
    parameter int STAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic [STAT_W-1:0] clr_i,
    output logic [STAT_W-1:0] status
);
    // Flag update: clear selected bits, then apply sets.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_i) | set_i;
    end

    // R11: a set bit reads back as one
    a_r11_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status & $past(set_i)) == $past(set_i)));
    // R11: a clear without a set reads back as zero
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((status & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/pwr_domain_seq.sv
// Top of the switchable-domain sleep/wake controller on the 32 kHz clock.
// Builds the sleep configuration from the control inputs, runs the step
// sequencer, decodes domain controls and keeps the reset status flags.
module pwr_domain_seq
    import pwr_seq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int WAKE_DLY  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pd_en,
    input  logic                 virt_off,
    input  logic                 wake_fixed,
    input  logic                 pd_clk_lf,
    input  logic [NUM_BANKS-1:0] ret_mask,
    input  logic                 sd_en,
    input  logic                 dbg_active,
    input  logic                 deep_sleep,
    input  logic                 wake_evt,
    input  logic [1:0]           rst_flag_set,
    input  logic [1:0]           rst_flag_clr,
    output logic                 dom_pwr_on,
    output logic                 dom_rst,
    output logic [1:0]           dom_clk_sel,
    output logic [NUM_BANKS-1:0] ram_ret,
    output logic [NUM_BANKS-1:0] ram_off,
    output logic                 shutdown_o,
    output logic [1:0]           rst_status
);
    sleep_cfg_t cfg_in, cfg_q;
    seq_state_t state;
    clk_sel_t   clk_sel_w;
    logic [NUM_BANKS-1:0] mask_q;

    // Power-down disabled behaves as a virtual power-off.
    always_comb begin
        cfg_in.virt  = virt_off || !pd_en;
        cfg_in.shut  = sd_en;
        cfg_in.lf    = pd_clk_lf;
        cfg_in.fixed = wake_fixed;
    end

    pwr_seq_fsm #(.NUM_BANKS(NUM_BANKS), .WAKE_DLY(WAKE_DLY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .deep_sleep(deep_sleep), .wake_evt(wake_evt),
        .dbg_active(dbg_active), .cfg_in(cfg_in), .mask_in(ret_mask),
        .state(state), .cfg_q(cfg_q), .mask_q(mask_q)
    );

    pwr_seq_outmap #(.NUM_BANKS(NUM_BANKS)) u_map (
        .state(state), .virt(cfg_q.virt), .shut(cfg_q.shut), .lf(cfg_q.lf),
        .mask_q(mask_q), .pwr_on(dom_pwr_on), .rst_o(dom_rst),
        .clk_sel(clk_sel_w), .ret_o(ram_ret), .off_o(ram_off), .shut_o(shutdown_o)
    );

    assign dom_clk_sel = clk_sel_w;

    pwr_rst_status #(.STAT_W(2)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_i(rst_flag_set), .clr_i(rst_flag_clr),
        .status(rst_status)
    );

    // R2: power is only off with reset held and the fast clock removed
    a_r2_off_order: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_pwr_on |-> (dom_rst && dom_clk_sel != CLK_HF));
    // R5: no bank is both retained and switched off
    a_r5_bank_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_ret & ram_off) == '0);
    // R2: reset leads the clock change on the way down
    a_r2_rst_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dom_clk_sel) == CLK_HF && dom_clk_sel != CLK_HF) |-> $past(dom_rst));
endmodule

// File: tb/pwr_domain_seq_tb_top.sv
module pwr_domain_seq_tb_top;
    localparam int NB  = 4;
    localparam int DLY = 16;

    logic clk = 0, rst_n = 0;
    logic pd_en = 1, virt_off = 0, wake_fixed = 0, pd_clk_lf = 0, sd_en = 0;
    logic dbg_active = 0, deep_sleep = 0, wake_evt = 0;
    logic [NB-1:0] ret_mask = '0;
    logic [1:0] rst_flag_set = '0, rst_flag_clr = '0;
    logic dom_pwr_on, dom_rst, shutdown_o;
    logic [1:0] dom_clk_sel, rst_status;
    logic [NB-1:0] ram_ret, ram_off;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_domain_seq #(.NUM_BANKS(NB), .WAKE_DLY(DLY)) dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    task automatic chk_active(input string tag);
        chk({tag, " pwr"}, 32'(dom_pwr_on), 1);
        chk({tag, " rst"}, 32'(dom_rst), 0);
        chk({tag, " clk"}, 32'(dom_clk_sel), 3);
        chk({tag, " ram"}, {ram_ret, ram_off}, 0);
        chk({tag, " sd"}, 32'(shutdown_o), 0);
    endtask

    function automatic logic [1:0] f_pd_src(input logic sd, input logic lf);
        return sd ? 2'b00 : (lf ? 2'b01 : 2'b00);
    endfunction
    function automatic logic f_real(input logic sd, input logic virt, input logic pden);
        return sd || (!virt && pden);
    endfunction
    function automatic logic [NB-1:0] f_ret(input logic r, input logic sd, input logic [NB-1:0] m);
        return (r && !sd) ? m : '0;
    endfunction
    function automatic logic [NB-1:0] f_off(input logic r, input logic sd, input logic [NB-1:0] m);
        return r ? (sd ? '1 : ~m) : '0;
    endfunction

    // Full down-and-up sequence with every step checked.
    task automatic run_cycle(input logic virt, input logic pden, input logic lf,
                             input logic fix, input logic sd, input logic [NB-1:0] m);
        logic r;
        logic [1:0] src;
        r   = f_real(sd, virt, pden);
        src = f_pd_src(sd, lf);
        virt_off = virt; pd_en = pden; pd_clk_lf = lf; wake_fixed = fix;
        sd_en = sd; ret_mask = m; deep_sleep = 1;
        @(negedge clk); deep_sleep = 0;
        chk("R2 step1 rst", 32'(dom_rst), 1);
        chk("R2 step1 clk", 32'(dom_clk_sel), 3);
        chk("R2 step1 pwr", 32'(dom_pwr_on), 1);
        @(negedge clk);
        chk("R3 step2 clk", 32'(dom_clk_sel), 32'(src));
        chk("R2 step2 pwr", 32'(dom_pwr_on), 1);
        @(negedge clk);
        chk("R4 down pwr", 32'(dom_pwr_on), 32'(!r));
        chk("R5 down ret", 32'(ram_ret), 32'(f_ret(r, sd, m)));
        chk("R5 down off", 32'(ram_off), 32'(f_off(r, sd, m)));
        chk("R9 down sd", 32'(shutdown_o), 32'(sd));
        ret_mask = ~m; pd_clk_lf = !lf; virt_off = !virt; sd_en = !sd;
        @(negedge clk);
        chk("R12 hold ret", 32'(ram_ret), 32'(f_ret(r, sd, m)));
        chk("R12 hold clk", 32'(dom_clk_sel), 32'(src));
        chk("R12 hold pwr", 32'(dom_pwr_on), 32'(!r));
        wake_evt = 1;
        if (fix) begin
            for (int k = 0; k < DLY; k++) begin
                @(negedge clk); wake_evt = 0;
                chk("R7 wait pwr", 32'(dom_pwr_on), 32'(!r));
                chk("R7 wait clk", 32'(dom_clk_sel), 32'(src));
            end
        end
        @(negedge clk); wake_evt = 0;
        chk("R6 up pwr", 32'(dom_pwr_on), 1);
        chk("R6 up rst", 32'(dom_rst), 1);
        chk("R6 up clk", 32'(dom_clk_sel), 32'(src));
        @(negedge clk);
        chk("R3 up hf", 32'(dom_clk_sel), 3);
        chk("R6 up rst2", 32'(dom_rst), 1);
        @(negedge clk);
        chk_active("R6 active");
        sd_en = 0;
    endtask

    initial begin
        logic [1:0] exp_st;
        process::self().srandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_active("R1 reset");
        chk("R1 status", 32'(rst_status), 0);

        run_cycle(0, 1, 1, 0, 0, 4'b0101);  // real, LF, immediate
        run_cycle(0, 1, 0, 1, 0, 4'b1010);  // real, no clock, fixed
        run_cycle(1, 1, 1, 0, 0, 4'b1111);  // R4 virtual via mode
        run_cycle(0, 0, 0, 1, 0, 4'b0011);  // R4 virtual via pd disabled
        run_cycle(0, 1, 1, 0, 1, 4'b1111);  // R9 shut-down

        // R8: debug blocks the sleep request
        dbg_active = 1; deep_sleep = 1; sd_en = 1;
        repeat (3) begin @(negedge clk); chk_active("R8 dbg"); end
        dbg_active = 0; deep_sleep = 0;
        // R9: shut-down enable alone does nothing
        repeat (3) begin @(negedge clk); chk_active("R9 no sleep"); end
        sd_en = 0;
        // R12: wake while active is ignored
        wake_evt = 1; @(negedge clk); wake_evt = 0;
        chk_active("R12 wake idle");

        // R10: abort during the reset step
        pd_en = 1; virt_off = 0; deep_sleep = 1;
        @(negedge clk); deep_sleep = 0; wake_evt = 1;
        @(negedge clk); wake_evt = 0;
        chk_active("R10 abort rst");
        // R10: abort during the clock-gating step
        deep_sleep = 1;
        @(negedge clk); deep_sleep = 0;
        @(negedge clk); wake_evt = 1;
        @(negedge clk); wake_evt = 0;
        chk_active("R10 abort clk");

        // Random mixed configurations
        for (int i = 0; i < 24; i++)
            run_cycle(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom_range(0, 3) == 0), NB'($urandom));

        // R11: status flags, set wins over clear
        exp_st = 0;
        rst_flag_set = 2'b11; rst_flag_clr = 2'b11;
        @(negedge clk); exp_st = 2'b11;
        chk("R11 set wins", 32'(rst_status), 32'(exp_st));
        for (int i = 0; i < 30; i++) begin
            rst_flag_set = 2'($urandom); rst_flag_clr = 2'($urandom);
            exp_st = (exp_st & ~rst_flag_clr) | rst_flag_set;
            @(negedge clk);
            chk("R11 w1c", 32'(rst_status), 32'(exp_st));
        end
        rst_flag_set = 0; rst_flag_clr = 2'b01;
        @(negedge clk); exp_st = exp_st & 2'b10;
        chk("R11 clear warm", 32'(rst_status), 32'(exp_st));
        rst_flag_clr = 0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule